// File: doc/BRIEF.md
# Asynchronous PSRAM Page-Read Bus Controller

This block sits between a simple host request port and an asynchronous pseudo-SRAM bus. The host presents one request at a time: a word address, a read or write flag, 16-bit write data with two byte enables, and for reads a word count of one to eight. The controller turns each request into a memory bus cycle. It drives active-low chip select, output enable, write enable and the upper and lower byte strobes. It also drives a registered output-enable for the shared data bus.

Every timing minimum is a parameter counted in system clock cycles: the first-access time, the page-access time, the write setup, the write pulse width and the inter-cycle recovery gap.

A multi-word read stays inside one chip-select assertion. It holds the upper address bits and steps only the three low bits, wrapping within the eight-word page, at the shorter page-access interval. The host sees one acknowledge pulse per word returned and one acknowledge per write.

Top module: `psram_page_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, chip select, output enable, write enable and both byte strobes are high (inactive), the data driver enable is 0, the acknowledge is 0, the read data is 0 and the request-ready output is 1.
- R2: An accepted read holds chip select, output enable and both byte strobes low and write enable high for T_ACC cycles. It then pulses the acknowledge for one cycle with the bus data that was sampled at the end of that interval.
- R3: A read with length field L (word count L+1, L in 0..7) returns L+1 words. Word k uses the request address with bits [2:0] replaced by (start bits [2:0] + k) mod 8, while the upper bits stay unchanged. Each word after the first takes T_PAGE cycles, and chip select stays low from the first word through the last acknowledge.
- R4: An accepted write drives the address and data, holds chip select low, and sets upper strobe low = be[1] and lower strobe low = be[0] for T_WSU cycles with write enable high. Write enable is then low for T_WP cycles. In the next cycle all strobes return high, the data driver is released and the acknowledge pulses.
- R5: Write enable is low only while chip select is low, at least one byte strobe is low and the data driver is enabled.
- R6: The memory address changes only when write enable is high both in that cycle and in the one before.
- R7: The data driver enable is 0 in every cycle in which output enable is low, and also in the cycle just before it.
- R8: After each request the controller keeps chip select, write enable and both byte strobes high for T_HIGH cycles with request-ready at 0. Request-ready is 1 only when the controller is idle.
- R9: Output enable and write enable are never low in the same cycle.
- R10: A write with byte enables 00 keeps the same cycle timing and acknowledge as R4, but write enable never goes low and the memory contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte, bit 0 = lower byte |
| req_len | input | 3 | Read word count minus one |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_ack | output | 1 | One-cycle pulse per returned word or completed write |
| rsp_rdata | output | 16 | Read word, valid with rsp_ack on reads |
| mem_addr | output | AW | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_o | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | 16 | Data read from the bus |

## Verification
Four rules are checked by properties on every cycle: read and write strobes never overlap, the data driver never meets an active output enable, write enable falls only inside a selected, strobed and driven window, and the address moves only while write enable is high. The same properties check the minimum chip-select high gap, the minimum write pulse width and that the page upper bits stay fixed during a burst. The cycle counts of first and page accesses, the wrapped low-address order, the captured data and the byte-merged results of partial and empty writes depend on the memory contents and on the request sequence. Only the bench's scenarios, with its memory model and per-cycle expected bus values, can show those.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_RECOV
  } psc_state_e;
endpackage

// File: rtl/psc_timer.sv
module psc_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/psc_page_step.sv
module psc_page_step #(
  parameter int AW        = 21,
  parameter int PAGE_BITS = 3
) (
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  logic [PAGE_BITS-1:0] low_inc;

  assign low_inc = cur[PAGE_BITS-1:0] + 1'b1;
  assign nxt     = {cur[AW-1:PAGE_BITS], low_inc};
endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
  import psc_pkg::*;
#(
  parameter int AW        = 21,
  parameter int PAGE_BITS = 3,
  parameter int T_ACC     = 5,
  parameter int T_PAGE    = 2,
  parameter int T_WSU     = 1,
  parameter int T_WP      = 3,
  parameter int T_HIGH    = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [1:0]           req_be,
  input  logic [PAGE_BITS-1:0] req_len,
  output logic                 req_ready,
  output logic                 rsp_ack,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_cs_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic                 mem_ub_n,
  output logic                 mem_lb_n,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_i
);
  localparam int TMAX_A = (T_ACC > T_PAGE) ? T_ACC : T_PAGE;
  localparam int TMAX_B = (T_WP > T_WSU) ? T_WP : T_WSU;
  localparam int TMAX_C = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TMAX   = (TMAX_C > T_HIGH) ? TMAX_C : T_HIGH;
  localparam int CW     = $clog2(TMAX + 1);

  localparam logic [CW-1:0] V_ACC  = CW'(T_ACC - 1);
  localparam logic [CW-1:0] V_PAGE = CW'(T_PAGE - 1);
  localparam logic [CW-1:0] V_WSU  = CW'(T_WSU - 1);
  localparam logic [CW-1:0] V_WP   = CW'(T_WP - 1);
  localparam logic [CW-1:0] V_HIGH = CW'(T_HIGH - 1);

  psc_state_e           state;
  logic [PAGE_BITS-1:0] words_left;
  logic                 be_none;
  logic                 tmr_load;
  logic [CW-1:0]        tmr_val;
  logic                 tmr_zero;
  logic [AW-1:0]        addr_next;

  psc_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  psc_page_step #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_step (
    .cur (mem_addr),
    .nxt (addr_next)
  );

  // Interval selection for the shared down-counter
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        tmr_val  = req_write ? V_WSU : V_ACC;
      end
      ST_READ: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = (words_left != '0) ? V_PAGE : V_HIGH;
      end
      ST_WSETUP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = V_WP;
      end
      ST_WPULSE: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = V_HIGH;
      end
      default: ;
    endcase
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      words_left <= '0;
      be_none    <= 1'b0;
      rsp_ack    <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_dq_o   <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_ack <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_cs_n <= 1'b0;
          if (req_write) begin
            mem_ub_n  <= ~req_be[1];
            mem_lb_n  <= ~req_be[0];
            mem_dq_o  <= req_wdata;
            mem_dq_oe <= 1'b1;
            be_none   <= (req_be == 2'b00);
            state     <= ST_WSETUP;
          end else begin
            mem_oe_n   <= 1'b0;
            mem_ub_n   <= 1'b0;
            mem_lb_n   <= 1'b0;
            words_left <= req_len;
            state      <= ST_READ;
          end
        end
        ST_READ: if (tmr_zero) begin
          rsp_rdata <= mem_dq_i;
          rsp_ack   <= 1'b1;
          if (words_left != '0) begin
            words_left <= words_left - 1'b1;
            mem_addr   <= addr_next;
          end else begin
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_ub_n <= 1'b1;
            mem_lb_n <= 1'b1;
            state    <= ST_RECOV;
          end
        end
        ST_WSETUP: if (tmr_zero) begin
          mem_we_n <= be_none;
          state    <= ST_WPULSE;
        end
        ST_WPULSE: if (tmr_zero) begin
          mem_cs_n  <= 1'b1;
          mem_we_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          rsp_ack   <= 1'b1;
          state     <= ST_RECOV;
        end
        ST_RECOV: if (tmr_zero) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psram_page_ctrl_chk.sv
module psram_page_ctrl_chk #(
  parameter int AW        = 21,
  parameter int PAGE_BITS = 3,
  parameter int T_WP      = 3,
  parameter int T_HIGH    = 1
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic          mem_dq_oe
);
  logic [7:0] cs_hi;
  logic [7:0] we_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hi <= '0;
      we_lo <= '0;
    end else begin
      cs_hi <= mem_cs_n  ? ((cs_hi == 8'hFF) ? cs_hi : cs_hi + 8'd1) : 8'd0;
      we_lo <= !mem_we_n ? ((we_lo == 8'hFF) ? we_lo : we_lo + 8'd1) : 8'd0;
    end
  end

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> mem_we_n);

  // R7
  dq_oe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));

  // R5
  we_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && !(mem_ub_n && mem_lb_n) && mem_dq_oe));

  // R6
  addr_move_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_addr != $past(mem_addr)) |-> (mem_we_n && $past(mem_we_n)));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cs_n) |-> (cs_hi >= 8'(T_HIGH)));

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo >= 8'(T_WP)));

  // R3
  page_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |->
      (mem_addr[AW-1:PAGE_BITS] == $past(mem_addr[AW-1:PAGE_BITS])));
endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
  .AW(AW), .PAGE_BITS(PAGE_BITS), .T_WP(T_WP), .T_HIGH(T_HIGH)
) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
  .mem_lb_n(mem_lb_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/psram_page_ctrl_bench.sv
`timescale 1ns/1ps
module psram_page_ctrl_bench;
  localparam int AW = 21, T_ACC = 5, T_PAGE = 2, T_WSU = 1, T_WP = 3, T_HIGH = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic [2:0] req_len = '0;
  logic req_ready, rsp_ack;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;
  logic mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [15:0] phys [0:63];
  logic [15:0] expv [0:63];

  always #10 clk = ~clk;

  psram_page_ctrl #(.AW(AW), .T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_WSU(T_WSU),
                    .T_WP(T_WP), .T_HIGH(T_HIGH)) u_psram_page_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_len(req_len),
    .req_ready(req_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  // Memory model: drives data while selected and output-enabled
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n) ? phys[mem_addr[5:0]] : 16'hBEEF;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n) begin
      if (!mem_ub_n) phys[mem_addr[5:0]][15:8] = mem_dq_o[15:8];
      if (!mem_lb_n) phys[mem_addr[5:0]][7:0]  = mem_dq_o[7:0];
    end
  end

  function automatic logic [7:0] ctl();
    return {mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rsp_ack, req_ready};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic recover_to_idle();
    for (int k = 1; k < T_HIGH; k++) begin
      chk("R8 recovery gap", ctl(), 8'b11111000);
      @(negedge clk);
    end
    chk("R8 idle ready", ctl(), 8'b11111001);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int n);
    logic [AW-1:0] cur;
    chk("R8 ready before read", req_ready, 1'b1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_len = 3'(n - 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < n; w++) begin
      cur = {a[AW-1:3], 3'(a[2:0] + 3'(w))};
      for (int k = 0; k < ((w == 0) ? T_ACC : T_PAGE - 1); k++) begin
        chk(w == 0 ? "R2 access strobes" : "R3 page strobes", ctl(), 8'b00100000);
        chk("R3 page address", mem_addr, cur);
        @(negedge clk);
      end
      chk("R2 R3 read data", rsp_rdata, expv[cur[5:0]]);
      if (w < n - 1) begin
        chk("R3 ack mid burst", ctl(), 8'b00100010);
        chk("R3 wrapped next address", mem_addr, {a[AW-1:3], 3'(a[2:0] + 3'(w + 1))});
      end else begin
        chk("R2 last ack", ctl(), 8'b11111010);
      end
      @(negedge clk);
    end
    recover_to_idle();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    chk("R8 ready before write", req_ready, 1'b1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < T_WSU; k++) begin
      chk("R4 write setup", ctl(), {3'b011, ~be[1], ~be[0], 3'b100});
      chk("R4 write address", mem_addr, a);
      chk("R4 write data", mem_dq_o, d);
      @(negedge clk);
    end
    for (int k = 0; k < T_WP; k++) begin
      chk(be == 2'b00 ? "R10 no pulse" : "R4 write pulse", ctl(),
          {2'b01, (be == 2'b00), ~be[1], ~be[0], 3'b100});
      @(negedge clk);
    end
    chk("R4 R10 write ack", ctl(), 8'b11111010);
    if (be[1]) expv[a[5:0]][15:8] = d[15:8];
    if (be[0]) expv[a[5:0]][7:0]  = d[7:0];
    @(negedge clk);
    recover_to_idle();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      phys[i] = 16'(i * 16'h0101) ^ 16'h5A00;
      expv[i] = 16'(i * 16'h0101) ^ 16'h5A00;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", ctl(), 8'b11111001);
    chk("R1 reset rdata", rsp_rdata, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", ctl(), 8'b11111001);
    do_read(21'h12345, 1);      // R2 single word
    do_read(21'h0A8A8, 8);      // R3 full page from offset 0
    do_read(21'h1FFFE, 4);      // R3 wrap 6,7,0,1
    do_write(21'h00011, 16'hC0DE, 2'b11);   // R4 both bytes
    do_write(21'h00012, 16'h1234, 2'b01);   // R4 lower only
    do_write(21'h00013, 16'hABCD, 2'b10);   // R4 upper only
    do_write(21'h00014, 16'h7777, 2'b00);   // R10 no byte
    do_read(21'h00010, 8);      // read back merged bytes
    do_write(21'h00017, 16'h0F0F, 2'b11);
    do_read(21'h00016, 3);      // R3 wrap over written word
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule